// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block turns single-word read and write requests from a clocked host into the control waveforms of an asynchronous static RAM holding 32K words of 9 bits. It drives a 15-bit word address, an active-low and an active-high chip select, an active-low write strobe and an active-low output enable. It also steers the memory's shared 9-bit data bus through a separate output value, output-enable and input, which the pad ring merges into one tri-state bus.

Every phase of an access lasts a whole number of clock cycles, set by parameters: address/data setup ahead of the write strobe, write strobe width, read access wait and bus turnaround after a read. A write ends with a single rising edge of the write strobe. Chip selects, address and write data stay valid for one full cycle after that edge. The output enable stays high through every write, and the data drivers switch on only after it has been high for the turnaround time. The host sees `ready_o` while the controller is idle and a one-cycle `ack_o` for each completed request. Read data is held on `rdata_o` until the next read completes.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_ni` is low: both chip selects are inactive (`sram_ce1_n_o`=1, `sram_ce2_o`=0), `sram_we_n_o`=1, `sram_oe_n_o`=1, `sram_dq_oe_o`=0, `ready_o`=1, `ack_o`=0 and `rdata_o`=0.
- R2: `ready_o` is 1 exactly while the controller is idle. A request is taken on a rising clock edge with `req_i`=1 and `ready_o`=1. A request raised while `ready_o`=0 is ignored: no pin activity and no acknowledge come from it. `wr_i`=1 selects a write and `wr_i`=0 a read.
- R3: In a write taken at edge 0, cycles 1..SETUP_CYC have the chip selects active, the address and write data driven and `sram_we_n_o`=1. The next WE_CYC cycles have `sram_we_n_o`=0. One final cycle follows with `sram_we_n_o`=1 while chip selects, address and data are still driven. The controller is idle after that.
- R4: The word presented during a write is the one later returned by a read of the same address, and a second write to an address replaces the first.
- R5: `sram_oe_n_o` stays 1 for the whole of a write, and `sram_we_n_o` and `sram_oe_n_o` are never both 0.
- R6: In a read taken at edge 0, cycles 1..ACC_CYC have the chip selects active, `sram_oe_n_o`=0, `sram_we_n_o`=1 and `sram_dq_oe_o`=0. `sram_dq_i` is captured at the edge that ends cycle ACC_CYC, and `rdata_o` keeps that value until the next read capture.
- R7: After a read, `sram_oe_n_o` is 1 and the chip selects are inactive for TURN_CYC cycles before the controller is idle. `sram_dq_oe_o` is never 1 while the memory drives the bus, and it is never 1 unless `sram_oe_n_o` was already 1 in the previous cycle.
- R8: `ack_o` is 1 for exactly one cycle per completed request: in cycle SETUP_CYC+WE_CYC+1 of a write and in cycle ACC_CYC+TURN_CYC of a read. `ack_o` is never 1 together with `ready_o`.
- R9: `sram_addr_o` shows the accepted address from the cycle the chip selects turn active, and it does not change while they stay active.
- R10: The two chip selects always agree: `sram_ce2_o` equals the inverse of `sram_ce1_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Host word address |
| wdata_i | input | 9 | Host write data |
| ready_o | output | 1 | Controller idle, request may be issued |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 9 | Last word read |
| sram_addr_o | output | 15 | Memory address |
| sram_ce1_n_o | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | 9 | Data value driven toward memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | 9 | Data bus value read back |

## Verification
The controller runs isolated writes and reads, back-to-back write-then-read and read-then-write pairs, and a second write to the same address. The pairs separate a correct turnaround from a design that drives the bus while the memory still drives it. The overwrite shows that the stored word follows the final strobe edge and not the first one. Data patterns 0x000, 0x1FF, 0x155 and 0x0AA at addresses 0, 0x7FFF and in between show whether every bit and the address extremes reach the pins. A request raised while the controller is busy must leave the pin timeline untouched. The memory model returns a fixed filler value until the output enable has been low for a full cycle, so a capture taken one cycle early reads the filler instead of the stored word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } seq_state_e;

  // active-high internal pin intent
  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
    logic drv;
  } pin_ctl_t;

  function automatic pin_ctl_t decode_pins(seq_state_e s);
    pin_ctl_t p;
    p = '0;
    case (s)
      ST_WSETUP: begin p.ce = 1'b1; p.drv = 1'b1; end
      ST_WPULSE: begin p.ce = 1'b1; p.we = 1'b1; p.drv = 1'b1; end
      ST_WHOLD:  begin p.ce = 1'b1; p.drv = 1'b1; end
      ST_RACC:   begin p.ce = 1'b1; p.oe = 1'b1; end
      default:   p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int ACC_CYC   = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             tmr_done_i,
  output seq_state_e       nxt_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ack_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WE    = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);

  seq_state_e state_q, nxt;

  always_comb begin
    nxt        = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        nxt        = wr_i ? ST_WSETUP : ST_RACC;
        load_o     = 1'b1;
        load_val_o = wr_i ? LD_SETUP : LD_ACC;
      end
      ST_WSETUP: if (tmr_done_i) begin
        nxt        = ST_WPULSE;
        load_o     = 1'b1;
        load_val_o = LD_WE;
      end
      ST_WPULSE: if (tmr_done_i) nxt = ST_WHOLD;
      ST_WHOLD:  nxt = ST_IDLE;
      ST_RACC: if (tmr_done_i) begin
        nxt        = ST_RTURN;
        load_o     = 1'b1;
        load_val_o = LD_TURN;
        capture_o  = 1'b1;
      end
      ST_RTURN: if (tmr_done_i) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= nxt;
  end

  assign nxt_o    = nxt;
  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_i;
  assign ack_o    = (state_q == ST_WHOLD) || ((state_q == ST_RTURN) && tmr_done_i);

  // R8: completion pulse lasts one cycle
  a_r8_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R2: busy and acknowledging never overlap with idle
  a_r2_ack_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ready_o);
  // R2: a request is taken only while idle
  a_r2_leave_idle_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !req_i) |=> ready_o);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= dq_i;
  end

  // R6: read data changes only on a capture edge
  a_r6_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(capture_i) |-> $stable(rdata_o));

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e nxt_i,
  output logic       ce1_n_o,
  output logic       ce2_o,
  output logic       we_n_o,
  output logic       oe_n_o,
  output logic       dq_oe_o
);

  pin_ctl_t pin_q;

  // registered so strobes never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= decode_pins(nxt_i);
  end

  assign ce1_n_o = ~pin_q.ce;
  assign ce2_o   =  pin_q.ce;
  assign we_n_o  = ~pin_q.we;
  assign oe_n_o  = ~pin_q.oe;
  assign dq_oe_o =  pin_q.drv;

  // R5: strobes mutually exclusive
  a_r5_we_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o));
  // R3: strobe low only inside a selected, driven window
  a_r3_we_needs_ce_drv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (!ce1_n_o && ce2_o && dq_oe_o));
  // R7: drivers on only after output enable was already high
  a_r7_drv_after_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_n_o && $past(oe_n_o)));
  // R3: strobe end keeps select and drivers for one more cycle
  a_r3_we_end_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |=> (!ce1_n_o && dq_oe_o) || $past(!ce1_n_o && dq_oe_o));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 9,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int ACC_CYC   = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce1_n_o,
  output logic              sram_ce2_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int MAX_A   = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAX_B   = (ACC_CYC > TURN_CYC) ? ACC_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       nxt;
  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_seq_fsm #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC),
    .ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (wr_i),
    .tmr_done_i (tmr_done),
    .nxt_o      (nxt),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ack_o      (ack_o),
    .ready_o    (ready_o)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .rdata_o   (rdata_o)
  );

  sram_pin_drv u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nxt_i   (nxt),
    .ce1_n_o (sram_ce1_n_o),
    .ce2_o   (sram_ce2_o),
    .we_n_o  (sram_we_n_o),
    .oe_n_o  (sram_oe_n_o),
    .dq_oe_o (sram_dq_oe_o)
  );

  // R9: address frozen across a selected window
  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce1_n_o && $past(!sram_ce1_n_o)) |-> $stable(sram_addr_o));
  // R3: write data settled before the strobe's rising edge
  a_r3_data_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (!sram_ce1_n_o && sram_dq_oe_o && $stable(sram_dq_o)));
  // R5: output enable high whenever drivers are on
  a_r5_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

  localparam int S = 2;
  localparam int W = 3;
  localparam int A = 2;
  localparam int T = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, wr_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [8:0]  wdata_i = '0;
  logic       ready_o, ack_o;
  logic [8:0] rdata_o;
  logic [14:0] sram_addr_o;
  logic       sram_ce1_n_o, sram_ce2_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o;
  logic [8:0] sram_dq_o;
  logic [8:0] sram_dq_i = 9'h0AA;

  always #5 clk_i = ~clk_i;

  sram_async_ctrl #(.SETUP_CYC(S), .WE_CYC(W), .ACC_CYC(A), .TURN_CYC(T)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .ack_o(ack_o),
    .rdata_o(rdata_o), .sram_addr_o(sram_addr_o), .sram_ce1_n_o(sram_ce1_n_o),
    .sram_ce2_o(sram_ce2_o), .sram_we_n_o(sram_we_n_o), .sram_oe_n_o(sram_oe_n_o),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o), .sram_dq_i(sram_dq_i)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural memory
  logic [8:0] mem_m [int];
  function automatic logic [8:0] mem_get(input int a);
    if (mem_m.exists(a)) return mem_m[a];
    return 9'h000;
  endfunction

  // reference timeline
  bit         busy_m = 0, wr_m = 0;
  int         k_m = 0, len_m = 0;
  logic [14:0] addr_m = '0;
  logic [8:0]  wdata_m = '0, exp_rd_m = '0, last_rd = '0;
  bit         rd_seen = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_m = 0;
    end else begin
      bit idle_before;
      idle_before = !busy_m;
      if (busy_m) begin
        k_m++;
        if (k_m > len_m) busy_m = 0;
      end
      if (idle_before && req_i) begin
        busy_m  = 1;
        k_m     = 1;
        wr_m    = wr_i;
        addr_m  = addr_i;
        wdata_m = wdata_i;
        len_m   = wr_i ? (S + W + 1) : (A + T);
        exp_rd_m = mem_get(int'(addr_i));
      end
    end
  end

  bit prev_we_n = 1, prev_rd_mode = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit e_ce, e_we_n, e_oe_n, e_drv, e_ack, rd_mode;
      e_ce = 0; e_we_n = 1; e_oe_n = 1; e_drv = 0; e_ack = 0;
      if (busy_m) begin
        e_ack = (k_m == len_m);
        if (wr_m) begin
          e_ce = 1; e_drv = 1;
          e_we_n = !(k_m > S && k_m <= S + W);
        end else begin
          e_ce = (k_m <= A);
          e_oe_n = !(k_m <= A);
          if (k_m == A + 1) begin last_rd = exp_rd_m; rd_seen = 1; end
        end
      end
      chk(sram_ce1_n_o == !e_ce, e_ce && wr_m ? "R3" : "R6", "ce1_n", sram_ce1_n_o, !e_ce);
      chk(sram_ce2_o == !sram_ce1_n_o, "R10", "ce2", sram_ce2_o, !sram_ce1_n_o);
      chk(sram_we_n_o == e_we_n, "R3", "we_n", sram_we_n_o, e_we_n);
      chk(sram_oe_n_o == e_oe_n, (busy_m && wr_m) ? "R5" : "R6", "oe_n", sram_oe_n_o, e_oe_n);
      chk(sram_dq_oe_o == e_drv, "R7", "dq_oe", sram_dq_oe_o, e_drv);
      chk(ready_o == !busy_m, "R2", "ready", ready_o, !busy_m);
      chk(ack_o == e_ack, "R8", "ack", ack_o, e_ack);
      if (e_ce) chk(sram_addr_o == addr_m, "R9", "addr", sram_addr_o, addr_m);
      if (e_drv) chk(sram_dq_o == wdata_m, "R3", "dq_o", sram_dq_o, wdata_m);
      if (rd_seen) chk(rdata_o == last_rd, "R6", "rdata", rdata_o, last_rd);
      rd_mode = !sram_ce1_n_o && sram_ce2_o && !sram_oe_n_o && sram_we_n_o;
      chk(!(sram_dq_oe_o && rd_mode), "R7", "bus contention", sram_dq_oe_o, 0);
      // memory stores on the strobe's rising edge
      if (!prev_we_n && sram_we_n_o && !sram_ce1_n_o && sram_ce2_o)
        mem_m[int'(sram_addr_o)] = sram_dq_o;
      sram_dq_i = (rd_mode && prev_rd_mode) ? mem_get(int'(sram_addr_o)) : 9'h0AA;
      prev_we_n = sram_we_n_o;
      prev_rd_mode = rd_mode;
    end
  end

  task automatic issue(input bit wr, input logic [14:0] a, input logic [8:0] d);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
  endtask

  task automatic read_expect(input logic [14:0] a, input logic [8:0] exp, input string tag);
    issue(1'b0, a, 9'h000);
    wait_idle();
    chk(rdata_o == exp, tag, "readback", rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk(sram_ce1_n_o == 1'b1 && sram_ce2_o == 1'b0, "R1", "reset ce", {sram_ce1_n_o, sram_ce2_o}, 2'b10);
    chk(sram_we_n_o && sram_oe_n_o, "R1", "reset strobes", {sram_we_n_o, sram_oe_n_o}, 2'b11);
    chk(!sram_dq_oe_o, "R1", "reset dq_oe", sram_dq_oe_o, 0);
    chk(ready_o && !ack_o, "R1", "reset ready/ack", {ready_o, ack_o}, 2'b10);
    chk(rdata_o == 9'h000, "R1", "reset rdata", rdata_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    issue(1'b1, 15'h0000, 9'h1FF); wait_idle();
    issue(1'b1, 15'h7FFF, 9'h000); wait_idle();
    issue(1'b1, 15'h1234, 9'h155);
    // R2 request while busy must be ignored
    req_i = 1'b1; wr_i = 1'b1; addr_i = 15'h0555; wdata_i = 9'h0F0;
    @(negedge clk_i);
    req_i = 1'b0;
    wait_idle();
    read_expect(15'h0555, 9'h000, "R2");
    read_expect(15'h0000, 9'h1FF, "R4");
    read_expect(15'h7FFF, 9'h000, "R4");
    // back-to-back: read then write then read (R7 turnaround)
    issue(1'b0, 15'h1234, 9'h000);
    issue(1'b1, 15'h2000, 9'h0AA);
    issue(1'b0, 15'h2000, 9'h000);
    wait_idle();
    chk(rdata_o == 9'h0AA, "R7", "write after read readback", rdata_o, 9'h0AA);
    // overwrite
    issue(1'b1, 15'h1234, 9'h03C); wait_idle();
    read_expect(15'h1234, 9'h03C, "R4");
    // R6 hold across a write
    issue(1'b1, 15'h0001, 9'h111); wait_idle();
    chk(rdata_o == 9'h03C, "R6", "rdata held over write", rdata_o, 9'h03C);
    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL R2 watchdog actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule